// File: doc/BRIEF.md
# Byte-Banked Unaligned Word Reader

This block fetches a 32-bit word at any byte address from a memory made of four byte-wide banks. All four banks are driven by one shared row address, and bank `k` always supplies byte lane `k` of the read data. The two lowest address bits name the bank that holds the first byte of the word. The remaining bits form the row.

A word that starts in bank 0 lies entirely in one row, so it takes a single bank access. A word that starts in bank 1, 2 or 3 runs past the last bank and wraps into the row above. For such a word the block reads row R and then row R+1. It rotates the lanes so the byte at the requested address lands in the lowest byte, and it merges the two reads into one result.

The request side is valid/ready. `req_ready` is high only while the block is idle. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. While `req_ready` is low, the requester is back-pressured: anything offered on `req_valid`/`req_addr` is not taken and has no effect. A held request is taken on the first edge after the block returns to idle. The response is a one-cycle `done` pulse with `rsp_data` valid in that cycle. The response cannot be stalled. The banks return data one cycle after `bank_rd_en`.

Top module: `byte_bank_word_reader`

## Requirements
- R1: After reset, `req_ready` is 1 and `busy`, `done` and `bank_rd_en` are 0. While `busy` is 0, `bank_rd_en` and `done` stay 0.
- R2: Bank k (k = 0..3) drives `bank_rdata[8k+7:8k]`. The first access of every request puts `req_addr[31:2]` on `bank_row`.
- R3: When `req_addr[1:0]` is 00, the request uses exactly one access cycle, and it raises `done` two cycles after the accepting edge.
- R4: When `req_addr[1:0]` is not 00, the request uses exactly two access cycles in a row, and it raises `done` three cycles after the accepting edge.
- R5: The result is little-endian: byte j of `rsp_data` (bits 8j+7:8j) holds the memory byte at `req_addr + j`.
- R6: On a split word, the lanes at or above the offset come from row R in the first access. The lanes below the offset come from row R+1 in the second access.
- R7: `busy` is high from the cycle after the accepting edge through the `done` cycle, and `req_ready` equals the inverse of `busy`. A request held valid during the `done` cycle is taken on the next edge.
- R8: A request offered while `busy` is high is not taken. It does not change the rows read, the access count or the result of the request in flight, and it produces no extra `done`.
- R9: On the second access, the row address increments modulo 2^30, so row all-ones is followed by row 0.
- R10: `done` is a one-cycle pulse, and each accepted request produces exactly one pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request offered |
| req_ready | output | 1 | Block idle, request will be taken |
| req_addr | input | 32 | Byte address of the word |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| rsp_data | output | 32 | Assembled word, valid with `done` |
| bank_rd_en | output | 1 | Read strobe common to all banks |
| bank_row | output | 30 | Row address common to all banks |
| bank_rdata | input | 32 | Bank read data, lane k from bank k, one cycle after strobe |

## Verification
The completion of one request and the arrival of the next can fall in the same cycle. In the `done` cycle the block is still busy, so a request held valid in that cycle must be refused, and it must then be taken on the following edge. The bench runs most of its requests back to back and raises the next request exactly in the `done` cycle of the previous one. It then checks three things: the wait is exactly one cycle, the word reported in that `done` belongs to the earlier address, and the later request's rows, access count and result are unaffected.

// File: rtl/bbr_pkg.sv
package bbr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2,
    ST_LAST   = 2'd3
  } rd_state_e;
endpackage

// File: rtl/bbr_seq.sv
module bbr_seq
  import bbr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic misaligned,
  output logic req_ready,
  output logic accept,
  output logic rd_en,
  output logic next_row,
  output logic capture,
  output logic done,
  output logic busy
);
  rd_state_e st_q, st_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:   if (req_valid) st_d = ST_FIRST;
      ST_FIRST:  st_d = misaligned ? ST_SECOND : ST_LAST;
      ST_SECOND: st_d = ST_LAST;
      ST_LAST:   st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  // second access reads the row above; first-row bytes land during it
  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign rd_en     = (st_q == ST_FIRST) || (st_q == ST_SECOND);
  assign next_row  = (st_q == ST_SECOND);
  assign capture   = (st_q == ST_SECOND);
  assign done      = (st_q == ST_LAST);
  assign busy      = (st_q != ST_IDLE);
endmodule

// File: rtl/bbr_row_gen.sv
module bbr_row_gen #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 2,
  parameter int ROW_W  = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr,
  input  logic              next_row,
  output logic [ROW_W-1:0]  row,
  output logic [OFF_W-1:0]  off,
  output logic              misaligned
);
  logic [ROW_W-1:0] row_q;
  logic [OFF_W-1:0] off_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
      off_q <= '0;
    end else if (load) begin
      row_q <= addr[ADDR_W-1:OFF_W];
      off_q <= addr[OFF_W-1:0];
    end
  end

  // natural wrap of the increment gives all-ones -> zero
  assign row        = next_row ? row_q + ROW_W'(1) : row_q;
  assign off        = off_q;
  assign misaligned = (off_q != '0);
endmodule

// File: rtl/bbr_lane_merge.sv
module bbr_lane_merge #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  parameter int OFF_W  = $clog2(LANES),
  parameter int WORD_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [OFF_W-1:0]  off,
  input  logic [WORD_W-1:0] rdata,
  output logic [WORD_W-1:0] word
);
  logic [WORD_W-1:0] rot;
  logic [WORD_W-1:0] hold_q;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    localparam logic [OFF_W:0] JOFF = (OFF_W+1)'(j);
    logic [OFF_W:0]   idx;
    logic [OFF_W-1:0] bank;
    logic             from_first;

    assign idx        = {1'b0, off} + JOFF;
    assign bank       = idx[OFF_W-1:0];
    // below the wrap point the byte belongs to the first row
    assign from_first = (off != '0) && !idx[OFF_W];
    assign rot[j*LANE_W +: LANE_W]  = rdata[bank*LANE_W +: LANE_W];
    assign word[j*LANE_W +: LANE_W] = from_first ? hold_q[j*LANE_W +: LANE_W]
                                                 : rot[j*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (capture) hold_q <= rot;
  end
endmodule

// File: rtl/byte_bank_word_reader.sv
module byte_bank_word_reader #(
  parameter int ADDR_W = 32,
  parameter int LANE_W = 8,
  parameter int LANES  = 4,
  localparam int OFF_W  = $clog2(LANES),
  localparam int ROW_W  = ADDR_W - OFF_W,
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] rsp_data,
  output logic              bank_rd_en,
  output logic [ROW_W-1:0]  bank_row,
  input  logic [WORD_W-1:0] bank_rdata
);
  logic accept, next_row, capture, misaligned;
  logic [OFF_W-1:0] off;

  bbr_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .misaligned(misaligned),
    .req_ready (req_ready),
    .accept    (accept),
    .rd_en     (bank_rd_en),
    .next_row  (next_row),
    .capture   (capture),
    .done      (done),
    .busy      (busy)
  );

  bbr_row_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .ROW_W(ROW_W)) u_row (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .addr      (req_addr),
    .next_row  (next_row),
    .row       (bank_row),
    .off       (off),
    .misaligned(misaligned)
  );

  bbr_lane_merge #(.LANES(LANES), .LANE_W(LANE_W), .OFF_W(OFF_W), .WORD_W(WORD_W)) u_merge (
    .clk    (clk),
    .rst_n  (rst_n),
    .capture(capture),
    .off    (off),
    .rdata  (bank_rdata),
    .word   (rsp_data)
  );
endmodule

// File: rtl/bbr_checker.sv
module bbr_checker #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 2,
  parameter int ROW_W  = 30
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              busy,
  input logic              done,
  input logic              bank_rd_en,
  input logic [ROW_W-1:0]  bank_row
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!bank_rd_en && !done));

  a_r3_aligned_one: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_addr[OFF_W-1:0] == '0)
      |=> (bank_rd_en ##1 (done && !bank_rd_en)));

  a_r4_split_two: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_addr[OFF_W-1:0] != '0)
      |=> (bank_rd_en ##1 bank_rd_en ##1 (done && !bank_rd_en)));

  a_r9_next_row: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_rd_en && $past(bank_rd_en)) |-> (bank_row == ROW_W'($past(bank_row) + 1'b1)));

  a_r7_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);

  a_r8_refuse_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind byte_bank_word_reader bbr_checker #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .ROW_W(ROW_W)) u_bbr_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_addr  (req_addr),
  .busy      (busy),
  .done      (done),
  .bank_rd_en(bank_rd_en),
  .bank_row  (bank_row)
);

// File: tb/byte_bank_word_reader_tb_top.sv
`timescale 1ns/1ps
module byte_bank_word_reader_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        busy, done, bank_rd_en;
  logic [31:0] rsp_data;
  logic [29:0] bank_row;
  logic [31:0] bank_rdata = '0;

  always #2.5 clk = ~clk;

  byte_bank_word_reader dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .busy(busy), .done(done), .rsp_data(rsp_data),
    .bank_rd_en(bank_rd_en), .bank_row(bank_row), .bank_rdata(bank_rdata)
  );

  typedef struct {
    logic [31:0] addr;
    logic [31:0] exp_data;
    int          exp_acc;
    int          exp_lat;
    int          acc_cyc;
  } item_t;

  item_t       sb_q[$];
  int          total = 0, bad = 0, cyc = 0, n_sent = 0, n_done = 0, acc_cnt = 0;
  logic [29:0] rows [2];

  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    return a[7:0] ^ a[31:24] ^ a[19:12] ^ 8'h3C;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // bank model: one-cycle latency, bank k on lane k (R2)
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (bank_rd_en)
      for (int k = 0; k < 4; k++) bank_rdata[8*k +: 8] <= mem_byte({bank_row, 2'(k)});
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (bank_rd_en) begin
        if (acc_cnt < 2) rows[acc_cnt] = bank_row;
        acc_cnt++;
      end
      if (done) begin
        n_done++;
        check(busy, "R7 busy during done", 32'(busy), 32'd1);
        if (sb_q.size() == 0) begin
          check(1'b0, "R10 done without request", 32'd1, 32'd0);
        end else begin
          item_t it;
          logic [29:0] r0;
          it = sb_q.pop_front();
          r0 = it.addr[31:2];
          check(rsp_data == it.exp_data, "R5/R6 word", rsp_data, it.exp_data);
          check(acc_cnt == it.exp_acc, "R3/R4 access count", 32'(acc_cnt), 32'(it.exp_acc));
          check(cyc - it.acc_cyc == it.exp_lat, "R3/R4 latency", 32'(cyc - it.acc_cyc), 32'(it.exp_lat));
          check(rows[0] == r0, "R2 first row", 32'(rows[0]), 32'(r0));
          if (it.exp_acc == 2)
            check(rows[1] == r0 + 30'd1, "R9/R6 second row", 32'(rows[1]), 32'(r0 + 30'd1));
        end
        acc_cnt = 0;
      end
    end
  end

  // driver: called at a falling edge; returns at the falling edge after acceptance
  task automatic send(input logic [31:0] a, output int waits);
    bit r;
    item_t it;
    req_valid = 1'b1;
    req_addr  = a;
    waits     = 0;
    forever begin
      r = req_ready;
      @(posedge clk);
      @(negedge clk);
      if (r) break;
      waits++;
    end
    it.addr    = a;
    for (int j = 0; j < 4; j++) it.exp_data[8*j +: 8] = mem_byte(a + 32'(j));
    it.exp_acc = (a[1:0] == 2'b00) ? 1 : 2;
    it.exp_lat = it.exp_acc;   // falling edge after accept to done falling edge
    it.acc_cyc = cyc;
    sb_q.push_back(it);
    n_sent++;
    req_valid = 1'b0;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done);
  endtask

  task automatic finish_run();
    check(sb_q.size() == 0, "R10 pending items", 32'(sb_q.size()), 32'd0);
    check(n_done == n_sent, "R10 done count", 32'(n_done), 32'(n_sent));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    check(1'b0, "watchdog", 32'(cyc), 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int w;
    logic [31:0] lfsr;
    logic [31:0] bases [3];
    bases[0] = 32'h0000_1000; bases[1] = 32'h1234_5670; bases[2] = 32'h8000_0040;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(req_ready == 1'b1, "R1 ready in reset", 32'(req_ready), 32'd1);
    check(!busy, "R1 busy in reset", 32'(busy), 32'd0);
    check(!done, "R1 done in reset", 32'(done), 32'd0);
    check(!bank_rd_en, "R1 rd_en in reset", 32'(bank_rd_en), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !busy && !bank_rd_en, "R1 idle after reset", {busy, bank_rd_en}, 32'd0);

    // every offset at several rows (R3 R4 R5 R6)
    for (int b = 0; b < 3; b++)
      for (int o = 0; o < 4; o++) begin
        send(bases[b] + 32'(o), w);
        wait_done();
        @(negedge clk);
      end

    // top of the address space: row wrap (R9)
    for (int o = 0; o < 4; o++) begin
      send(32'hFFFF_FFFC + 32'(o), w);
      wait_done();
      @(negedge clk);
    end

    // request offered while busy is ignored (R8)
    send(32'h0000_2001, w);
    req_valid = 1'b1;
    req_addr  = 32'hDEAD_BEE0;
    check(!req_ready, "R8 refused while busy", 32'(req_ready), 32'd0);
    @(negedge clk);
    req_valid = 1'b0;
    wait_done();
    repeat (4) @(negedge clk);
    check(!busy && n_done == n_sent, "R8 no extra request", 32'(n_done), 32'(n_sent));

    // request held during the done cycle is taken on the next edge (R7)
    send(32'h0000_3003, w);
    wait_done();
    send(32'h0000_3002, w);
    check(w == 1, "R7 one-cycle wait after done", 32'(w), 32'd1);
    wait_done();

    // back-to-back stream, each raised in the previous done cycle (R7 R10)
    lfsr = 32'hACE1_2357;
    for (int n = 0; n < 40; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      send(lfsr, w);
      check(w == 1, "R7 back-to-back wait", 32'(w), 32'd1);
      wait_done();
    end
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule